// File: doc/BRIEF.md
# Box-Average Video Downscaler

The block accepts a pixel-clock stream of 24-bit RGB pixels, framed by active-high horizontal and vertical blanking strobes, and shrinks each frame to a coarse grid. Each coarse pixel is the box average of a rectangle of source pixels. At the defaults a 1920×1080 frame becomes a grid of about 60×34, and each axis is reduced by 32.

The work is split across two stages. A front stage averages each run of four horizontal pixels and emits one sample every four clocks. It also produces a half-rate clock enable. A second stage runs only on that enable. It adds each sample into a running per-column sum held in a two-bank line RAM, using one read step and then one write step. When a band of lines is complete, the second stage swaps banks and pulses a ready strobe with the band's row index. A downstream consumer then reads the finished row by column while the next band is being built in the other bank.

Top module: `box_downscale`

## Requirements
- R1: After reset, line_ready_o is 0 and line_addr_o is 0.
- R2: A pixel is active only while both hsync_i and vsync_i are low. Pixel data presented during blanking has no effect on any result. Channels are packed as R in bits [23:16], G in bits [15:8] and B in bits [7:0], and the same packing is used on rd_pix_o.
- R3: For each channel, the front stage outputs floor(sum of 2^PRE_LOG2 consecutive active pixels / 2^PRE_LOG2). Groups restart at the first active pixel of every line. It emits at most one sample in any two consecutive clocks.
- R4: Coarse pixel (row r, column c) per channel is floor(S / 2^(HDIV_LOG2+VDIV_LOG2)). S is the sum of the front-stage samples c·2^HDIV_LOG2 to c·2^HDIV_LOG2+2^HDIV_LOG2−1 of lines r·2^VDIV_LOG2 to r·2^VDIV_LOG2+2^VDIV_LOG2−1, and line numbers count active lines from the start of the frame.
- R5: After every 2^VDIV_LOG2 active lines, line_ready_o is high for exactly one clock. In that clock line_addr_o carries the band index, which starts at 0 in each frame.
- R6: Once line_ready_o has pulsed, setting rd_col_i = c yields that band's coarse pixel c on rd_pix_o on the next clock. The value stays readable until the next line_ready_o pulse.
- R7: A band's sums start from zero, so values from earlier bands or frames never leak into a later result.
- R8: At the rising edge of vsync_i, a partially filled band (frame height not a multiple of 2^VDIV_LOG2) is still flagged with a line_ready_o pulse. Its value uses the same shift as a full band, so missing lines count as zero. A frame whose height is an exact multiple produces no extra pulse.
- R9: Lines with no active pixels, such as hsync_i pulses during vertical blanking, do not advance the line count.
- R10: The second stage advances only on the half-rate enable. Each line RAM write comes two clocks after the read of the same entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 3*CH_W | RGB pixel, R in the top channel |
| hsync_i | input | 1 | Horizontal blanking, active high |
| vsync_i | input | 1 | Vertical blanking, active high |
| rd_col_i | input | COL_W | Consumer column select |
| line_ready_o | output | 1 | One-clock pulse when a coarse row is finished |
| line_addr_o | output | ROW_W | Index of the finished coarse row |
| rd_pix_o | output | 3*CH_W | Averaged RGB of the selected column, one clock after rd_col_i |

## Verification
The bench builds the block with PRE_LOG2=2, HDIV_LOG2=1, VDIV_LOG2=2 and MAX_COLS=MAX_ROWS=8. Each coarse pixel then covers 8×4 source pixels, so a 24-pixel line gives three columns. With these values, frames of 10, 8 and 9 lines are short enough to drive whole. They reach the partial-band case, the exact-multiple case and a one-line partial band, as well as several bank swaps and a frame-to-frame restart. An all-ones frame drives the per-channel sums to their widest value, which checks that the sum width (CH_W + HDIV_LOG2 + VDIV_LOG2) is enough.

// File: rtl/box_pkg.sv
package box_pkg;
  typedef enum logic {ST_IDLE, ST_WR} vacc_st_e;
  localparam int unsigned NCH = 3;
endpackage

// File: rtl/box_hpre.sv
module box_hpre #(
  parameter int unsigned CH_W     = 8,
  parameter int unsigned PRE_LOG2 = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3*CH_W-1:0]     pix_i,
  input  logic                  hsync_i,
  input  logic                  vsync_i,
  output logic [3*CH_W-1:0]     avg_o,
  output logic                  avg_vld_o,
  output logic                  hs_o,
  output logic                  vs_o,
  output logic                  ce2_o
);
  localparam int unsigned AW = CH_W + PRE_LOG2;

  logic                active;
  logic [PRE_LOG2-1:0] phase;
  logic [AW-1:0]       acc [box_pkg::NCH];

  assign active = !hsync_i && !vsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= '0;
      avg_o     <= '0;
      avg_vld_o <= 1'b0;
      hs_o      <= 1'b0;
      vs_o      <= 1'b0;
      ce2_o     <= 1'b0;
      for (int c = 0; c < box_pkg::NCH; c++) acc[c] <= '0;
    end else begin
      hs_o      <= hsync_i;   // one register of latency, same as the average
      vs_o      <= vsync_i;
      ce2_o     <= !ce2_o;
      avg_vld_o <= 1'b0;
      if (!active) begin
        phase <= '0;
        for (int c = 0; c < box_pkg::NCH; c++) acc[c] <= '0;
      end else if (phase == '1) begin
        phase     <= '0;
        avg_vld_o <= 1'b1;
        for (int c = 0; c < box_pkg::NCH; c++) begin
          avg_o[c*CH_W +: CH_W] <= CH_W'((acc[c] + AW'(pix_i[c*CH_W +: CH_W])) >> PRE_LOG2);
          acc[c] <= '0;
        end
      end else begin
        phase <= phase + 1'b1;
        for (int c = 0; c < box_pkg::NCH; c++)
          acc[c] <= acc[c] + AW'(pix_i[c*CH_W +: CH_W]);
      end
    end
  end
endmodule

// File: rtl/box_line_ram.sv
module box_line_ram #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned SUM_W = 16,
  parameter int unsigned SH    = 8,
  parameter int unsigned AW    = 7
) (
  input  logic                 clk_i,
  input  logic                 re_i,
  input  logic [AW-1:0]        raddr_i,
  output logic [3*SUM_W-1:0]   rdata_o,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [3*SUM_W-1:0]   wdata_i,
  input  logic [AW-1:0]        caddr_i,
  output logic [3*CH_W-1:0]    cdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [3*SUM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
    for (int c = 0; c < 3; c++)
      cdata_o[c*CH_W +: CH_W] <= CH_W'(mem[caddr_i][c*SUM_W +: SUM_W] >> SH);
  end
endmodule

// File: rtl/box_vacc.sv
module box_vacc
  import box_pkg::*;
#(
  parameter int unsigned CH_W      = 8,
  parameter int unsigned HDIV_LOG2 = 3,
  parameter int unsigned VDIV_LOG2 = 5,
  parameter int unsigned COL_W     = 6,
  parameter int unsigned ROW_W     = 6,
  localparam int unsigned SUM_W    = CH_W + HDIV_LOG2 + VDIV_LOG2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce2_i,
  input  logic [3*CH_W-1:0]     smp_i,
  input  logic                  smp_vld_i,
  input  logic                  hs_i,
  input  logic                  vs_i,
  output logic                  ram_re_o,
  output logic [COL_W:0]        ram_raddr_o,
  input  logic [3*SUM_W-1:0]    ram_rdata_i,
  output logic                  ram_we_o,
  output logic [COL_W:0]        ram_waddr_o,
  output logic [3*SUM_W-1:0]    ram_wdata_o,
  output logic                  bank_o,
  output logic                  line_ready_o,
  output logic [ROW_W-1:0]      line_addr_o
);
  vacc_st_e             st;
  logic                 hs_q, vs_q, eol_pend, eof_pend, pend, line_had, w_clr;
  logic [3*CH_W-1:0]    smp_q, w_smp;
  logic [COL_W:0]       w_addr;
  logic [HDIV_LOG2-1:0] x_sub;
  logic [VDIV_LOG2-1:0] y_sub;
  logic [COL_W-1:0]     col;
  logic [ROW_W-1:0]     row;

  assign ram_re_o    = ce2_i && (st == ST_IDLE) && pend;
  assign ram_raddr_o = {bank_o, col};
  assign ram_we_o    = ce2_i && (st == ST_WR);
  assign ram_waddr_o = w_addr;

  for (genvar c = 0; c < 3; c++) begin : g_add
    logic [SUM_W-1:0] ext;
    assign ext = SUM_W'(w_smp[c*CH_W +: CH_W]);
    assign ram_wdata_o[c*SUM_W +: SUM_W] = w_clr ? ext : ram_rdata_i[c*SUM_W +: SUM_W] + ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;
      hs_q <= 1'b0; vs_q <= 1'b0; eol_pend <= 1'b0; eof_pend <= 1'b0;
      pend <= 1'b0; line_had <= 1'b0; w_clr <= 1'b0;
      smp_q <= '0; w_smp <= '0; w_addr <= '0;
      x_sub <= '0; y_sub <= '0; col <= '0; row <= '0;
      bank_o <= 1'b0; line_ready_o <= 1'b0; line_addr_o <= '0;
    end else begin
      hs_q <= hs_i;
      vs_q <= vs_i;
      line_ready_o <= 1'b0;
      if (smp_vld_i) smp_q <= smp_i;
      if (smp_vld_i) pend <= 1'b1;
      else if (ram_re_o) pend <= 1'b0;
      if (hs_i && !hs_q) eol_pend <= 1'b1;
      if (vs_i && !vs_q) eof_pend <= 1'b1;
      if (ce2_i) begin
        case (st)
          ST_IDLE: begin
            if (pend) begin
              w_smp  <= smp_q;
              w_addr <= {bank_o, col};
              w_clr  <= (y_sub == '0) && (x_sub == '0);
              st     <= ST_WR;
            end else if (eol_pend) begin
              eol_pend <= 1'b0;
              x_sub    <= '0;
              col      <= '0;
              line_had <= 1'b0;
              if (line_had) begin
                if (y_sub == '1) begin
                  y_sub        <= '0;
                  bank_o       <= !bank_o;
                  line_ready_o <= 1'b1;
                  line_addr_o  <= row;
                  row          <= row + 1'b1;
                end else begin
                  y_sub <= y_sub + 1'b1;
                end
              end
            end else if (eof_pend) begin
              eof_pend <= 1'b0;
              row      <= '0;
              y_sub    <= '0;
              if (y_sub != '0) begin   // flush partial band
                bank_o       <= !bank_o;
                line_ready_o <= 1'b1;
                line_addr_o  <= row;
              end
            end
          end
          ST_WR: begin
            line_had <= 1'b1;
            x_sub    <= x_sub + 1'b1;
            if (x_sub == '1) col <= col + 1'b1;
            st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/box_downscale.sv
module box_downscale #(
  parameter int unsigned CH_W      = 8,
  parameter int unsigned PRE_LOG2  = 2,
  parameter int unsigned HDIV_LOG2 = 3,
  parameter int unsigned VDIV_LOG2 = 5,
  parameter int unsigned MAX_COLS  = 64,
  parameter int unsigned MAX_ROWS  = 64,
  localparam int unsigned COL_W    = $clog2(MAX_COLS),
  localparam int unsigned ROW_W    = $clog2(MAX_ROWS),
  localparam int unsigned SUM_W    = CH_W + HDIV_LOG2 + VDIV_LOG2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3*CH_W-1:0]     pix_i,
  input  logic                  hsync_i,
  input  logic                  vsync_i,
  input  logic [COL_W-1:0]      rd_col_i,
  output logic                  line_ready_o,
  output logic [ROW_W-1:0]      line_addr_o,
  output logic [3*CH_W-1:0]     rd_pix_o
);
  logic [3*CH_W-1:0]  pre_avg;
  logic               pre_vld, hs_d, vs_d, ce2, bank;
  logic               ram_re, ram_we;
  logic [COL_W:0]     ram_raddr, ram_waddr;
  logic [3*SUM_W-1:0] ram_rdata, ram_wdata;

  box_hpre #(.CH_W(CH_W), .PRE_LOG2(PRE_LOG2)) u_hpre (
    .clk_i, .rst_ni, .pix_i, .hsync_i, .vsync_i,
    .avg_o(pre_avg), .avg_vld_o(pre_vld), .hs_o(hs_d), .vs_o(vs_d), .ce2_o(ce2)
  );

  box_vacc #(.CH_W(CH_W), .HDIV_LOG2(HDIV_LOG2), .VDIV_LOG2(VDIV_LOG2),
             .COL_W(COL_W), .ROW_W(ROW_W)) u_vacc (
    .clk_i, .rst_ni, .ce2_i(ce2), .smp_i(pre_avg), .smp_vld_i(pre_vld),
    .hs_i(hs_d), .vs_i(vs_d),
    .ram_re_o(ram_re), .ram_raddr_o(ram_raddr), .ram_rdata_i(ram_rdata),
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata),
    .bank_o(bank), .line_ready_o, .line_addr_o
  );

  box_line_ram #(.CH_W(CH_W), .SUM_W(SUM_W), .SH(HDIV_LOG2 + VDIV_LOG2),
                 .AW(COL_W + 1)) u_ram (
    .clk_i, .re_i(ram_re), .raddr_i(ram_raddr), .rdata_o(ram_rdata),
    .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .caddr_i({!bank, rd_col_i}), .cdata_o(rd_pix_o)
  );
endmodule

// File: rtl/box_downscale_chk.sv
module box_downscale_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce2,
  input logic bank,
  input logic ram_re,
  input logic ram_we,
  input logic pre_vld,
  input logic line_ready_o
);
  // R5
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ready_o |=> !line_ready_o);
  // R10
  ready_on_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ready_o |-> $past(ce2));
  // R6
  bank_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ready_o |-> (bank != $past(bank)));
  // R10
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> $past(ram_re, 2));
  // R3
  pre_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_vld |=> !pre_vld);
endmodule

bind box_downscale box_downscale_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce2(ce2), .bank(bank), .ram_re(ram_re),
  .ram_we(ram_we), .pre_vld(pre_vld), .line_ready_o(line_ready_o)
);

// File: tb/tb_box_downscale.sv
module tb_box_downscale;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 24;   // 3 coarse columns of 8 pixels
  localparam int NCOL   = 3;
  localparam int NFR    = 3;
  localparam int MAXL   = 10;
  localparam int HBLANK = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pix = '0;
  logic        hs = 1'b1, vs = 1'b1;
  logic [2:0]  rd_col = '0;
  logic        ready;
  logic [2:0]  laddr;
  logic [23:0] rd_pix;

  int checks = 0, errors = 0;
  int nlines [NFR] = '{10, 8, 9};
  logic [23:0] img [NFR][MAXL][W];
  int exp_fr [16], exp_row [16];
  int n_exp = 0, n_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  box_downscale #(.CH_W(8), .PRE_LOG2(2), .HDIV_LOG2(1), .VDIV_LOG2(2),
                  .MAX_COLS(8), .MAX_ROWS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .hsync_i(hs), .vsync_i(vs),
    .rd_col_i(rd_col), .line_ready_o(ready), .line_addr_o(laddr), .rd_pix_o(rd_pix)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(int f, int r, int c, int ch);
    int s = 0;
    for (int l = r*4; l < r*4+4; l++) begin
      if (l < nlines[f]) begin
        for (int k = 0; k < 2; k++) begin
          int a = 0;
          for (int j = 0; j < 4; j++) a += img[f][l][(c*2+k)*4+j][ch*8 +: 8];
          s += a >> 2;
        end
      end
    end
    return s >> 3;
  endfunction

  task automatic vblank();
    for (int l = 0; l < 3; l++) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        vs = 1'b1; hs = (i >= 20); pix = $urandom;   // R9: sync pulses, garbage data
      end
    end
  endtask

  task automatic drive_frame(input int f);
    vblank();
    for (int l = 0; l < nlines[f]; l++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        vs = 1'b0; hs = 1'b0; pix = img[f][l][x];
      end
      for (int i = 0; i < HBLANK; i++) begin
        @(negedge clk);
        hs = 1'b1; pix = $urandom;   // R2: ignored during blanking
      end
    end
  endtask

  // monitor: each ready pulse, check row index and read the row back
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ready) begin
        int f, r;
        f = (n_seen < n_exp) ? exp_fr[n_seen] : 0;
        r = (n_seen < n_exp) ? exp_row[n_seen] : 0;
        chk(((r+1)*4 > nlines[f]) ? "R8 partial band row index" : "R5 band row index", laddr, r);
        for (int c = 0; c < NCOL; c++) begin
          rd_col = 3'(c);
          @(negedge clk);
          for (int ch = 0; ch < 3; ch++)
            chk(f == 0 ? "R4 R6 coarse pixel" : "R7 R8 coarse pixel after restart",
                rd_pix[ch*8 +: 8], ref_val(f, r, c, ch));
        end
        n_seen++;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int f = 0; f < NFR; f++)
      for (int l = 0; l < MAXL; l++)
        for (int x = 0; x < W; x++)
          img[f][l][x] = (f == 1) ? 24'hFFFFFF : 24'($urandom);
    img[0][0][0] = 24'h000000; img[0][0][1] = 24'h030303;   // truncation corner
    img[0][0][2] = 24'h030303; img[0][0][3] = 24'h030300;
    for (int f = 0; f < NFR; f++)
      for (int r = 0; r < (nlines[f]+3)/4; r++) begin
        exp_fr[n_exp] = f; exp_row[n_exp] = r; n_exp++;
      end

    repeat (4) @(negedge clk);
    chk("R1 ready at reset", ready, 0);
    chk("R1 line_addr at reset", laddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 0);
    for (int f = 0; f < NFR; f++) drive_frame(f);
    vblank();
    repeat (50) @(negedge clk);
    chk("R5 R8 R9 ready pulse count", n_seen, n_exp);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule